// File: doc/BRIEF.md
# DRAM Auto-Refresh Interval Timer with Module Rate Resolution

This block issues periodic auto-refresh requests for a DRAM controller. It takes the refresh-rate code reported by each installed memory module (up to four by default) together with a mask of which sockets hold a module. From these it works out the safest refresh interval the controller can run. The result is a 3-bit refresh mode. A down-counter, clocked at a known number of cycles per microsecond, turns that mode into a one-clock request strobe.

The resolver supports only two intervals. The slow default is 15.6 us. The fast interval, 7.8 us, is chosen as soon as any present module asks for it. A module that reports a rate the controller cannot honour raises an error flag. That module's code has no other effect on the chosen mode. The refresh command itself, and arbitration against other traffic, belong to the surrounding controller.

Top module: `refresh_timer_top`

## Requirements
- R1: After reset, `refresh_mode` is 000, and `refresh_req` and `code_err` are 0.
- R2: Mode encoding on `refresh_mode` is as follows. 000 means no refresh. 001 means one request every 15.6 us, which is CYC_PER_US*156/10 cycles. 010 means one request every 7.8 us, which is CYC_PER_US*78/10 cycles. The timer also runs 011 at 64 us. It treats 1xx as reserved and issues no requests for it.
- R3: Module codes are 7 bits wide. Codes 0, 3, 4 and 5 ask for the slow 15.6 us mode. Code 2 asks for the fast 7.8 us mode. When enabled with at least one module present, the mode is 010 if any present module reports code 2, and 001 otherwise. The mode is registered one clock after the inputs.
- R4: Sockets whose bit in `module_present` is 0 have no effect on `refresh_mode` or on `code_err`, whatever code they carry.
- R5: `code_err` is 1, one clock after the inputs, when any present module reports code 1 or any code above 5 (up to 127). Such a code does not change the mode chosen from the other modules. `code_err` does not depend on `refresh_en`.
- R6: When `refresh_en` is 0, or no module is present, `refresh_mode` is 000 and no request is issued.
- R7: Each request is high for exactly one clock. Consecutive requests in a steady mode are exactly one interval apart.
- R8: A change of mode reloads the interval counter at once. Counting from the clock edge that registers the new inputs, the first request of the new mode rises interval+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_en | input | 1 | Enables refresh generation |
| module_present | input | NUM_MODS | One bit per socket, 1 = module installed |
| module_codes | input | NUM_MODS*7 | 7-bit refresh code per socket, socket i at bits [7i+6:7i] |
| refresh_mode | output | 3 | Selected refresh mode |
| refresh_req | output | 1 | One-clock refresh request strobe |
| code_err | output | 1 | A present module reports an unsupported code |

## Verification
The resolver is driven with three kinds of module set. Sets with only slow codes must give 001. A single fast code mixed among slow ones must give 010. Unsupported codes (1, 6, 127) placed alongside supported ones must raise the error flag while the mode follows the supported codes. Fast and illegal codes placed in absent sockets show whether the mask is honoured. The timer is checked on the exact spacing of strobes in both intervals, on the first-strobe latency after enabling, and on a mid-interval switch from slow to fast. That switch separates an immediate reload from a wait for the old count to drain.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  localparam int CODE_W = 7;

  typedef enum logic [2:0] {
    RM_OFF  = 3'b000,
    RM_SLOW = 3'b001,
    RM_FAST = 3'b010,
    RM_LONG = 3'b011,
    RM_RSVD = 3'b111
  } rmode_e;

  typedef struct packed {
    logic ok;
    logic fast;
  } code_class_t;

  function automatic code_class_t classify(input logic [CODE_W-1:0] code);
    code_class_t c;
    c.ok   = (code == 7'd0) || ((code >= 7'd2) && (code <= 7'd5));
    c.fast = (code == 7'd2);
    return c;
  endfunction

  function automatic logic mode_active(input logic [2:0] m);
    return (m == RM_SLOW) || (m == RM_FAST) || (m == RM_LONG);
  endfunction

endpackage

// File: rtl/refresh_code_resolver.sv
module refresh_code_resolver
  import refresh_pkg::*;
#(
  parameter int NUM_MODS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [NUM_MODS-1:0]      present_i,
  input  logic [NUM_MODS*CODE_W-1:0] codes_i,
  output logic [2:0]               mode_o,
  output logic                     err_o
);

  logic [NUM_MODS-1:0] fast_vec;
  logic [NUM_MODS-1:0] bad_vec;

  for (genvar i = 0; i < NUM_MODS; i++) begin : g_sock
    code_class_t cls;
    assign cls         = classify(codes_i[i*CODE_W +: CODE_W]);
    assign fast_vec[i] = present_i[i] & cls.ok & cls.fast;
    assign bad_vec[i]  = present_i[i] & ~cls.ok;
  end

  logic [2:0] mode_n;
  logic       err_n;

  always_comb begin
    err_n = |bad_vec;
    if (!en_i || (present_i == '0)) mode_n = RM_OFF;
    else if (|fast_vec)             mode_n = RM_FAST;
    else                            mode_n = RM_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= RM_OFF;
      err_o  <= 1'b0;
    end else begin
      mode_o <= mode_n;
      err_o  <= err_n;
    end
  end

  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == RM_OFF) || (mode_o == RM_SLOW) || (mode_o == RM_FAST));

  assert_empty_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (present_i == '0) |=> (mode_o == RM_OFF));

  assert_disabled_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (mode_o == RM_OFF));

endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import refresh_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  output logic       req_o
);

  localparam int N_SLOW = CYC_PER_US * 156 / 10;
  localparam int N_FAST = CYC_PER_US * 78 / 10;
  localparam int N_LONG = CYC_PER_US * 64;
  localparam int CNT_W  = $clog2(N_LONG + 1);

  function automatic logic [CNT_W-1:0] reload_of(input logic [2:0] m);
    case (m)
      RM_SLOW: return CNT_W'(N_SLOW - 1);
      RM_FAST: return CNT_W'(N_FAST - 1);
      RM_LONG: return CNT_W'(N_LONG - 1);
      default: return '0;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [2:0]       mode_q;
  logic             req_n;

  always_comb begin
    cnt_n = cnt_q;
    req_n = 1'b0;
    if (mode_i != mode_q) begin
      cnt_n = reload_of(mode_i);
    end else if (mode_active(mode_i)) begin
      if (cnt_q == '0) begin
        req_n = 1'b1;
        cnt_n = reload_of(mode_i);
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= RM_OFF;
      req_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      mode_q <= mode_i;
      req_o  <= req_n;
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  assert_idle_noreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_active(mode_i)) |=> !req_o);

  assert_switch_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != mode_q) |=> (!req_o && (cnt_q == reload_of($past(mode_i)))));

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(N_LONG - 1));

endmodule

// File: rtl/refresh_timer_top.sv
module refresh_timer_top
  import refresh_pkg::*;
#(
  parameter int NUM_MODS   = 4,
  parameter int CYC_PER_US = 50
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       refresh_en,
  input  logic [NUM_MODS-1:0]        module_present,
  input  logic [NUM_MODS*CODE_W-1:0] module_codes,
  output logic [2:0]                 refresh_mode,
  output logic                       refresh_req,
  output logic                       code_err
);

  refresh_code_resolver #(.NUM_MODS(NUM_MODS)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (refresh_en),
    .present_i (module_present),
    .codes_i   (module_codes),
    .mode_o    (refresh_mode),
    .err_o     (code_err)
  );

  refresh_interval_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (refresh_mode),
    .req_o  (refresh_req)
  );

  assert_req_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> ($past(refresh_mode) != RM_OFF));

endmodule

// File: tb/sim_refresh_timer_top.sv
module sim_refresh_timer_top;

  localparam int NM  = 4;
  localparam int CPU = 5;
  localparam int I_SLOW = 78;
  localparam int I_FAST = 39;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en;
  logic [NM-1:0]   pres;
  logic [NM*7-1:0] codes;
  logic [2:0]      mode;
  logic            req;
  logic            err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  refresh_timer_top #(.NUM_MODS(NM), .CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .refresh_en(en), .module_present(pres),
    .module_codes(codes), .refresh_mode(mode), .refresh_req(req), .code_err(err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NM*7-1:0] pack(input int c0, input int c1, input int c2, input int c3);
    return {7'(c3), 7'(c2), 7'(c1), 7'(c0)};
  endfunction

  // drive at negedge, then sample one clock later
  task automatic apply(input logic e, input logic [NM-1:0] p, input logic [NM*7-1:0] c);
    @(negedge clk);
    en = e; pres = p; codes = c;
    @(negedge clk);
  endtask

  task automatic period_check(input string tag, input int exp);
    int k;
    k = 0;
    while (!req && k < 400) begin @(negedge clk); k++; end
    check({tag, " first strobe seen"}, int'(req), 1);
    @(negedge clk);
    check({tag, " strobe one clock"}, int'(req), 0);
    k = 1;
    while (!req && k < 400) begin @(negedge clk); k++; end
    check({tag, " interval"}, k, exp);
  endtask

  task automatic t_reset;
    check("R1 mode", int'(mode), 0);
    check("R1 req", int'(req), 0);
    check("R1 err", int'(err), 0);
  endtask

  task automatic t_latency;
    int first;
    first = -1;
    @(negedge clk);
    en = 1'b1; pres = 4'b0011; codes = pack(0, 3, 0, 0);
    for (int k = 1; k <= I_SLOW + 4; k++) begin
      @(negedge clk);
      if (req && first < 0) first = k;
    end
    check("R8 first strobe after enable", first, I_SLOW + 2);
  endtask

  task automatic t_slow_modes;
    apply(1'b1, 4'b1111, pack(0, 3, 4, 5));
    check("R3 slow codes mode", int'(mode), 1);
    check("R3 slow codes err", int'(err), 0);
    period_check("R2 R7 slow", I_SLOW);
  endtask

  task automatic t_fast;
    apply(1'b1, 4'b1011, pack(4, 2, 0, 5));
    check("R3 fast wins", int'(mode), 2);
    period_check("R2 R7 fast", I_FAST);
  endtask

  task automatic t_switch;
    int first;
    apply(1'b1, 4'b0001, pack(0, 0, 0, 0));
    while (!req) @(negedge clk);
    repeat (10) @(negedge clk);
    en = 1'b1; pres = 4'b0011; codes = pack(0, 2, 0, 0);
    first = -1;
    for (int k = 1; k <= I_FAST + 4; k++) begin
      @(negedge clk);
      if (req && first < 0) first = k;
    end
    check("R8 reload on switch", first, I_FAST + 2);
  endtask

  task automatic t_mask;
    apply(1'b1, 4'b0101, pack(3, 2, 0, 1));
    check("R4 absent fast ignored", int'(mode), 1);
    check("R4 absent bad ignored", int'(err), 0);
  endtask

  task automatic t_err;
    apply(1'b1, 4'b0011, pack(1, 0, 0, 0));
    check("R5 code1 err", int'(err), 1);
    check("R5 code1 mode", int'(mode), 1);
    apply(1'b1, 4'b0111, pack(6, 2, 0, 0));
    check("R5 code6 err", int'(err), 1);
    check("R5 code6 mode", int'(mode), 2);
    apply(1'b0, 4'b1000, pack(0, 0, 0, 127));
    check("R5 code127 err when disabled", int'(err), 1);
    apply(1'b1, 4'b1000, pack(0, 0, 0, 5));
    check("R5 code5 ok", int'(err), 0);
  endtask

  task automatic t_off;
    int seen;
    apply(1'b0, 4'b1111, pack(2, 2, 2, 2));
    check("R6 disabled mode", int'(mode), 0);
    seen = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); seen += int'(req); end
    check("R6 disabled no req", seen, 0);
    apply(1'b1, 4'b0000, pack(2, 2, 2, 2));
    check("R6 empty mask mode", int'(mode), 0);
    seen = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); seen += int'(req); end
    check("R6 empty mask no req", seen, 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; pres = '0; codes = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_slow_modes();
    t_fast();
    t_switch();
    t_mask();
    t_err();
    t_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule